// File: doc/BRIEF.md
# Glitch-free clock power-down controller

This block sits in front of a bank of differential clock output lanes and decides, cycle by cycle, whether each lane runs, is parked, or is driven to a defined level while the clock source settles. The output clock is modelled as a toggle of the block's own reference clock: the true leg follows the toggle, and the complement leg is its inverse. A polarity strap, captured once after reset, sets whether the power-down request, the per-lane enables and a global clock-stop input are active high or active low.

A power-down request is asynchronous. It is synchronized, then sampled on each rising edge of the complement clock. Only two active samples in a row stop the lanes, and they stop together on the following complement falling edge, so no shortened pulse leaves the block. A drive-mode bit chooses how a stopped lane is parked. In one style the true leg is held high and the complement leg is released. In the other, both legs are released. After the request is removed, the block waits out a lock delay before it restarts the lanes on a clean edge. In the second park style it first drives every lane to a defined level within a deadline. Both delays are cycle counts, and a simulation switch shortens them.

Top module: `clkpd_ctrl`

## Requirements
- R1: The strap input is captured on the first clock after reset and is held unchanged until the next reset; later changes on the strap pin have no effect.
- R2: With captured strap 0 the power-down, lane-enable and clock-stop inputs are active when 1; with strap 1 they are active when 0.
- R3: The power-down request passes a two-stage synchronizer and is sampled on every complement rising edge (true leg going 1 to 0). It takes effect only when two consecutive samples are active, so a request seen on a single sample is ignored.
- R4: Once qualified, every running lane stops on the next complement falling edge (true leg going 0 to 1). The last low half-period is full length and the true leg is high when the lane stops.
- R5: A parked lane with drive-mode 0 drives its true leg 1 with its enable set, and has its complement enable cleared (complement value 0).
- R6: A parked lane with drive-mode 1 has both leg enables cleared.
- R7: After release, and after reset, lanes restart only after at least LOCK_EFF cycles of lock wait, where LOCK_EFF = LOCK_CYC, or LOCK_CYC/SIM_DIV when SIM_SHORT is 1, with a minimum of 2. The restart lands on a complement falling edge with the true leg already high, so the first half-period is full length.
- R8: With drive-mode 1, every lane drives true 1 and complement 0 with both enables set from release until restart. This starts no later than DRIVE_EFF cycles after release, where DRIVE_EFF is derived from DRIVE_CYC in the same way as LOCK_EFF.
- R9: A running lane toggles its true leg every reference cycle, drives the complement leg as its inverse, and sets both enables.
- R10: A lane whose enable is inactive is parked while the other lanes run. Enable changes are applied only on a complement falling edge.
- R11: An active clock-stop input parks all lanes on a complement falling edge, and they resume when it is removed, without a lock wait.
- R12: During reset every lane is parked in the style set by the drive-mode bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; its toggle models the output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_pol_i | input | 1 | Polarity strap, captured once after reset |
| drive_mode_i | input | 1 | Park style select: 0 true-high, 1 both legs released |
| pdn_req_i | input | 1 | Asynchronous power-down request, polarity per strap |
| clk_stop_i | input | 1 | Global clock-stop input, polarity per strap |
| lane_en_i | input | N_LANES | Per-lane output enables, polarity per strap |
| lane_t_o | output | N_LANES | True leg value per lane |
| lane_t_oe_o | output | N_LANES | True leg output enable per lane |
| lane_c_o | output | N_LANES | Complement leg value per lane |
| lane_c_oe_o | output | N_LANES | Complement leg output enable per lane |

## Verification
The bench sweeps all four combinations of strap and drive-mode. For each one it applies a sustained power-down request and a pulse seen on only one sample edge. Their different outcomes separate two-sample qualification from a plain synchronizer, and the stop latency and the true-leg level at the stop show that the stop falls on the complement falling edge. Releases from reset and from power-down measure the lock wait. They also separate the two park styles by whether, and how soon, the drive-high phase appears. Disabling a single lane, stopping all lanes and toggling the strap pin after capture tell per-lane gating, global gating and polarity hold apart.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

    typedef enum logic [1:0] {
        ST_PARK = 2'd0,
        ST_LOCK = 2'd1,
        ST_RUN  = 2'd2,
        ST_PEND = 2'd3
    } pd_state_e;

    // Effective cycle count: optionally divided for simulation, never below 2.
    function automatic int eff_cycles(input int full, input bit shorten, input int div);
        int v;
        v = shorten ? (full / div) : full;
        return (v < 2) ? 2 : v;
    endfunction

endpackage

// File: rtl/clkpd_sync.sv
module clkpd_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] s1_q, s2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/clkpd_lane.sv
module clkpd_lane (
    input  logic run_i,
    input  logic phase_i,
    input  logic hold_i,
    input  logic mode_i,
    output logic t_o,
    output logic t_oe_o,
    output logic c_o,
    output logic c_oe_o
);
    always_comb begin
        if (run_i) begin
            t_o    = phase_i;
            c_o    = ~phase_i;
            t_oe_o = 1'b1;
            c_oe_o = 1'b1;
        end else if (hold_i) begin
            t_o    = 1'b1;
            c_o    = 1'b0;
            t_oe_o = 1'b1;
            c_oe_o = 1'b1;
        end else begin
            t_o    = 1'b1;
            c_o    = 1'b0;
            t_oe_o = ~mode_i;
            c_oe_o = 1'b0;
        end
    end
endmodule

// File: rtl/clkpd_ctrl.sv
module clkpd_ctrl
    import clkpd_pkg::*;
#(
    parameter int N_LANES   = 8,
    parameter int LOCK_CYC  = 125000,
    parameter int DRIVE_CYC = 37500,
    parameter bit SIM_SHORT = 1'b0,
    parameter int SIM_DIV   = 1000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               strap_pol_i,
    input  logic               drive_mode_i,
    input  logic               pdn_req_i,
    input  logic               clk_stop_i,
    input  logic [N_LANES-1:0] lane_en_i,
    output logic [N_LANES-1:0] lane_t_o,
    output logic [N_LANES-1:0] lane_t_oe_o,
    output logic [N_LANES-1:0] lane_c_o,
    output logic [N_LANES-1:0] lane_c_oe_o
);
    localparam int LOCK_EFF  = eff_cycles(LOCK_CYC, SIM_SHORT, SIM_DIV);
    localparam int DRIVE_EFF = eff_cycles(DRIVE_CYC, SIM_SHORT, SIM_DIV);
    localparam int CNT_W     = $clog2(LOCK_EFF + 1);
    localparam int SYNC_W    = N_LANES + 2;
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(LOCK_EFF);
    localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_EFF - 1);

    typedef struct packed {
        pd_state_e          state;
        logic               phase;
        logic               pol;
        logic               strap_done;
        logic               smp;
        logic [CNT_W-1:0]   cnt;
        logic [N_LANES-1:0] lane_on;
    } ctl_t;

    localparam ctl_t CTL_RST = '{state: ST_PARK, phase: 1'b0, pol: 1'b0, strap_done: 1'b0,
                                 smp: 1'b0, cnt: '0, lane_on: '0};

    ctl_t st_d, st_q;

    logic [SYNC_W-1:0]  sync_w;
    logic               pd_act, stop_act, samp_edge, fall_edge, hold_w;
    logic [N_LANES-1:0] en_act;

    // Observation points for the bound checker
    pd_state_e          state_w;
    logic               phase_w, pol_w, strap_done_w, pd_act_w;
    logic [N_LANES-1:0] lane_on_w;

    clkpd_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({pdn_req_i, clk_stop_i, lane_en_i}),
        .q_o   (sync_w)
    );

    // Complement rises when the true toggle leaves 1; it falls when the toggle leaves 0.
    assign samp_edge = st_q.phase;
    assign fall_edge = ~st_q.phase;
    assign pd_act    = st_q.strap_done & (sync_w[SYNC_W-1] ^ st_q.pol);
    assign stop_act  = sync_w[N_LANES] ^ st_q.pol;
    assign en_act    = (sync_w[N_LANES-1:0] ^ {N_LANES{st_q.pol}}) & {N_LANES{~stop_act}};
    assign hold_w    = (st_q.state == ST_LOCK) & drive_mode_i;

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        if (!st_q.strap_done) begin
            st_d.strap_done = 1'b1;
            st_d.pol        = strap_pol_i;
        end
        if (st_q.state == ST_LOCK && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (samp_edge) begin
            st_d.smp = pd_act;
        end
        unique case (st_q.state)
            ST_PARK: begin
                if (samp_edge && st_q.strap_done && !pd_act) begin
                    st_d.state = ST_LOCK;
                    st_d.cnt   = '0;
                end
            end
            ST_LOCK: begin
                if (samp_edge && pd_act && st_q.smp) begin
                    st_d.state = ST_PEND;
                end else if (fall_edge && st_q.cnt >= LOCK_LAST) begin
                    st_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (samp_edge && pd_act && st_q.smp) begin
                    st_d.state = ST_PEND;
                end
            end
            default: begin
                if (fall_edge) begin
                    st_d.state = ST_PARK;
                end
            end
        endcase
        if (fall_edge) begin
            st_d.lane_on = (st_d.state == ST_RUN) ? en_act : '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= CTL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_w      = st_q.state;
    assign phase_w      = st_q.phase;
    assign pol_w        = st_q.pol;
    assign strap_done_w = st_q.strap_done;
    assign pd_act_w     = pd_act;
    assign lane_on_w    = st_q.lane_on;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        clkpd_lane u_lane (
            .run_i  (lane_on_w[g]),
            .phase_i(st_q.phase),
            .hold_i (hold_w),
            .mode_i (drive_mode_i),
            .t_o    (lane_t_o[g]),
            .t_oe_o (lane_t_oe_o[g]),
            .c_o    (lane_c_o[g]),
            .c_oe_o (lane_c_oe_o[g])
        );
    end
endmodule

// File: rtl/clkpd_chk.sv
module clkpd_chk
    import clkpd_pkg::*;
#(
    parameter int N_LANES   = 8,
    parameter int LOCK_EFF  = 2,
    parameter int DRIVE_EFF = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               drive_mode_i,
    input pd_state_e          state_w,
    input logic               phase_w,
    input logic               pol_w,
    input logic               strap_done_w,
    input logic               pd_act_w,
    input logic [N_LANES-1:0] lane_on_w,
    input logic [N_LANES-1:0] lane_t_o,
    input logic [N_LANES-1:0] lane_t_oe_o,
    input logic [N_LANES-1:0] lane_c_o,
    input logic [N_LANES-1:0] lane_c_oe_o
);
    int lc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lc_q <= 0;
        end else begin
            lc_q <= (state_w == ST_LOCK) ? lc_q + 1 : 0;
        end
    end

    AST_STRAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) (strap_done_w && $past(strap_done_w)) |-> $stable(pol_w)) else $error("strap polarity changed"); // R1
    AST_QUAL_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_w == ST_PEND && $past(state_w) != ST_PEND) |-> ($past(pd_act_w) && $past(pd_act_w, 3))) else $error("stop without two samples"); // R3
    AST_STOP_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(lane_on_w[0]) |-> (phase_w && lane_t_o[0])) else $error("stop off complement falling edge"); // R4
    AST_RESTART_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(lane_on_w[0]) |-> (lane_t_o[0] && $past(lane_t_o[0]))) else $error("restart with short pulse"); // R7
    AST_LOCK_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_w == ST_RUN && $past(state_w) == ST_LOCK) |-> (lc_q >= LOCK_EFF)) else $error("lock wait too short"); // R7
    AST_DRIVE_DEADLINE: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_w == ST_LOCK && drive_mode_i && lc_q >= DRIVE_EFF) |-> ((&lane_t_oe_o) && (&lane_c_oe_o) && (&lane_t_o) && !(|lane_c_o))) else $error("drive-high missed deadline"); // R8

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane_chk
        AST_PARK_TRUE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni) (!lane_on_w[i] && !drive_mode_i) |-> (lane_t_oe_o[i] && lane_t_o[i] && !lane_c_oe_o[i])) else $error("bad mode-0 park"); // R5
        AST_PARK_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni) (!lane_on_w[i] && drive_mode_i && state_w != ST_LOCK) |-> (!lane_t_oe_o[i] && !lane_c_oe_o[i])) else $error("bad mode-1 park"); // R6
        AST_RUN_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) (lane_on_w[i] && $past(lane_on_w[i])) |-> (lane_t_o[i] != $past(lane_t_o[i]) && lane_c_o[i] == !lane_t_o[i] && lane_t_oe_o[i] && lane_c_oe_o[i])) else $error("running lane bad"); // R9
    end
endmodule

bind clkpd_ctrl clkpd_chk #(
    .N_LANES  (N_LANES),
    .LOCK_EFF (LOCK_EFF),
    .DRIVE_EFF(DRIVE_EFF)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drive_mode_i(drive_mode_i),
    .state_w     (state_w),
    .phase_w     (phase_w),
    .pol_w       (pol_w),
    .strap_done_w(strap_done_w),
    .pd_act_w    (pd_act_w),
    .lane_on_w   (lane_on_w),
    .lane_t_o    (lane_t_o),
    .lane_t_oe_o (lane_t_oe_o),
    .lane_c_o    (lane_c_o),
    .lane_c_oe_o (lane_c_oe_o)
);

// File: tb/clkpd_ctrl_tb.sv
module clkpd_ctrl_tb_top;
    localparam int NL      = 4;
    localparam int LOCK_E  = 125000 / 1000;
    localparam int DRIVE_E = 37500 / 1000;
    localparam int WD_CYC  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap = 1'b0;
    logic          mode = 1'b0;
    logic          pdn = 1'b0;
    logic          stop = 1'b0;
    logic [NL-1:0] en = '1;
    logic [NL-1:0] t, t_oe, c, c_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic cur_mode = 1'b0;

    always #4 clk = ~clk;

    clkpd_ctrl #(
        .N_LANES  (NL),
        .LOCK_CYC (125000),
        .DRIVE_CYC(37500),
        .SIM_SHORT(1'b1),
        .SIM_DIV  (1000)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .strap_pol_i (strap),
        .drive_mode_i(mode),
        .pdn_req_i   (pdn),
        .clk_stop_i  (stop),
        .lane_en_i   (en),
        .lane_t_o    (t),
        .lane_t_oe_o (t_oe),
        .lane_c_o    (c),
        .lane_c_oe_o (c_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Park style expected from R5 (mode 0) or R6 (mode 1)
    function automatic bit parked_ok(input int i);
        if (!cur_mode) return t_oe[i] && t[i] && !c_oe[i];
        return !t_oe[i] && !c_oe[i];
    endfunction

    function automatic bit all_parked();
        bit ok = 1'b1;
        for (int i = 0; i < NL; i++) ok &= parked_ok(i);
        return ok;
    endfunction

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts cycles until lane 0 first shows a running low half; notes first drive-high pattern.
    task automatic wait_restart(output int n, output int first_drive, output bit early);
        n = 0;
        first_drive = -1;
        early = 1'b0;
        while (n < LOCK_E + 40) begin
            @(negedge clk);
            n++;
            if (first_drive < 0 && t_oe[0] && c_oe[0] && t[0] && !c[0]) first_drive = n;
            if (c_oe[0] && !t[0]) break;
            if (!cur_mode && c_oe[0] && n < LOCK_E) early = 1'b1;
        end
    endtask

    task automatic run_cfg(input logic s, input logic m);
        int  n, fd, k;
        bit  early, ok, seen;
        logic [NL-1:0] prev;
        logic prev_t;
        cur_mode = m;
        rst_n = 1'b0;
        strap = s; mode = m;
        pdn = s;              // inactive (R2)
        stop = s;             // inactive
        en = {NL{~s}};        // all active
        wait_neg(3);
        chk(all_parked(), "R12 reset park", int'(c_oe), 0);
        rst_n = 1'b1;

        // R7/R8: start-up behaves as a release
        wait_restart(n, fd, early);
        chk(n >= LOCK_E && n <= LOCK_E + 12, "R7 start-up lock wait", n, LOCK_E + 3);
        if (m) chk(fd > 0 && fd <= DRIVE_E, "R8 start-up drive-high", fd, DRIVE_E);
        else chk(!early, "R7 start-up no early clock", int'(early), 0);

        // R9 running pattern, R2 inactive raw levels
        ok = 1'b1;
        prev = t;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            ok &= (t == ~prev) && (c == ~t) && (&t_oe) && (&c_oe);
            prev = t;
        end
        chk(ok, "R9 R2 running lanes", int'(t), int'(~prev));

        // R3 single-sample pulse ignored
        pdn = ~s;
        wait_neg(2);
        pdn = s;
        seen = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (c_oe != '1) seen = 1'b1;
        end
        chk(!seen, "R3 single-sample pulse", int'(seen), 0);

        // R3/R4 sustained request
        pdn = ~s;
        n = 0;
        prev_t = t[0];
        while (n < 20) begin
            @(negedge clk);
            n++;
            if (!c_oe[0]) break;
            prev_t = t[0];
        end
        chk(n >= 5 && n <= 9, "R3 qualified stop latency", n, 7);
        chk(prev_t == 1'b0 && t[0] == 1'b1, "R4 stop on complement falling edge", int'(prev_t), 0);
        chk(c_oe == '0, "R4 all lanes stop together", int'(c_oe), 0);
        ok = 1'b1;
        repeat (30) begin
            @(negedge clk);
            ok &= all_parked();
        end
        if (m) chk(ok, "R6 both legs released", int'(t_oe), 0);
        else chk(ok, "R5 true high complement released", int'(c_oe), 0);

        // R7/R8 release
        pdn = s;
        wait_restart(n, fd, early);
        chk(n >= LOCK_E && n <= LOCK_E + 12, "R7 release lock wait", n, LOCK_E + 5);
        if (m) chk(fd > 0 && fd <= DRIVE_E, "R8 release drive-high", fd, DRIVE_E);
        else chk(!early, "R7 release no early clock", int'(early), 0);

        // R10 single lane disable
        wait_neg(4);
        en[1] = s;
        wait_neg(6);
        chk(parked_ok(1) && c_oe[0] && c_oe[2], "R10 lane 1 parked", int'(c_oe), 13);
        en[1] = ~s;
        wait_neg(6);
        chk(c_oe[1] && t[1] == t[0], "R10 lane 1 rejoins in phase", int'(t[1]), int'(t[0]));

        // R11 global stop
        stop = ~s;
        wait_neg(6);
        chk(all_parked() && c_oe == '0, "R11 stop parks all", int'(c_oe), 0);
        stop = s;
        k = 0;
        wait_neg(6);
        if (&c_oe) k = 1;
        chk(k == 1, "R11 resume without lock wait", int'(c_oe), 15);

        // R1 strap pin changes after capture are ignored
        strap = ~s;
        wait_neg(12);
        chk(&c_oe, "R1 strap flip keeps running", int'(c_oe), 15);
        pdn = ~s;
        wait_neg(12);
        chk(c_oe[0] == 1'b0, "R1 R2 captured polarity still governs", int'(c_oe[0]), 0);
        pdn = s;
        strap = s;
        wait_neg(4);
    endtask

    initial begin
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 2; m++) begin
                run_cfg(s[0], m[0]);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", WD_CYC, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule